// File: doc/BRIEF.md
# Fixed-Point Single-Qubit Gate Stage

This block applies one single-qubit gate to a qubit state written as two complex amplitudes, alpha and beta. The state is carried as four signed fixed-point words: the real and imaginary parts of alpha, then the real and imaginary parts of beta. A 2-bit opcode picks the gate for each transfer. The gate can be a bit flip (X), a sign flip on beta (Z), a Hadamard, or a phase rotation of beta. The phase factor arrives with the data as a fixed-point cosine/sine pair.

Each word has a sign bit, one integer bit and `FRAC_BITS` fraction bits (format Q1.N, width N+2, range [-2, 2)). Changing `FRAC_BITS` resizes the whole datapath. Transfers use valid/ready on both sides. The result sits in an output register, so stages can be chained directly. A two-state controller (`ST_IDLE`: output register empty; `ST_HOLD`: output register holds a result) handles the handshake. The transitions are `ST_IDLE -> ST_HOLD` on acceptance, `ST_HOLD -> ST_HOLD` when the result leaves and a new one is accepted in the same cycle, or while the output stalls, and `ST_HOLD -> ST_IDLE` when the result leaves and nothing is accepted.

Top module: `qubit_gate_stage`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: A transfer is accepted on a rising edge where `in_valid` and `in_ready` are both 1. After that edge `out_valid` is 1 and the result is on the outputs. While `out_valid` is 1 and `out_ready` is 0, the outputs hold stable and `in_ready` is 0.
- R3: Opcode 00 (X) puts the input beta words on the alpha outputs and the input alpha words on the beta outputs, unchanged.
- R4: Opcode 01 (Z) passes alpha unchanged and negates both beta words. Negating -2.0 gives the largest positive code.
- R5: Opcode 10 (H) gives alpha' = (alpha+beta)·K and beta' = (alpha−beta)·K for the real and imaginary parts separately. K is 1/√2 rounded to the nearest N-bit fraction (46341 for N=16). Each product is floored to N fraction bits.
- R6: Opcode 11 (phase) passes alpha unchanged. Beta becomes (br·c − bi·s, br·s + bi·c), where c and s are `in_cos` and `in_sin`. Each result is floored to N fraction bits.
- R7: With N=16 and input alpha = beta = 1/√2 (code 46341), the Hadamard and the π/4 phase outputs lie within 2 LSB (about 3.1e-5) of the exact value.
- R8: Any result outside [-2, 2) saturates to the nearest end: code 2^(N+1)−1 or −2^(N+1).
- R9: With `out_ready` held at 1, a new transfer is accepted every cycle. Each result appears one cycle after its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Stage can accept a transfer |
| in_op | input | 2 | Gate select: 00 X, 01 Z, 10 H, 11 phase |
| in_a_re | input | FRAC_BITS+2 | Alpha real part, Q1.N |
| in_a_im | input | FRAC_BITS+2 | Alpha imaginary part |
| in_b_re | input | FRAC_BITS+2 | Beta real part |
| in_b_im | input | FRAC_BITS+2 | Beta imaginary part |
| in_cos | input | FRAC_BITS+2 | Phase factor real part (opcode 11) |
| in_sin | input | FRAC_BITS+2 | Phase factor imaginary part (opcode 11) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Downstream takes the result |
| out_a_re | output | FRAC_BITS+2 | Result alpha real part |
| out_a_im | output | FRAC_BITS+2 | Result alpha imaginary part |
| out_b_re | output | FRAC_BITS+2 | Result beta real part |
| out_b_im | output | FRAC_BITS+2 | Result beta imaginary part |

## Verification
The assertions assume that `in_op` and the data words are known and held steady whenever `in_valid` is high. They also assume `out_ready` is never unknown after reset. The amplitude relations they check are meaningful only for the cycle right after an acceptance. The stimulus drives every input on the falling edge and keeps all operands at defined codes, including the saturation extremes. During stalls it leaves `in_valid` raised with new data, so that the assertions on holding and refusal are exercised.

// File: rtl/qg_pkg.sv
package qg_pkg;

    typedef enum logic [1:0] {
        OP_X     = 2'b00,
        OP_Z     = 2'b01,
        OP_H     = 2'b10,
        OP_PHASE = 2'b11
    } gate_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } stage_state_e;

    // Nearest integer to 2^frac / sqrt(2) = sqrt(2^(2*frac-1)).
    function automatic longint inv_sqrt2_code(input int frac);
        longint x;
        longint r;
        longint b;
        x = longint'(1) << (2 * frac - 1);
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            b = r | (longint'(1) << i);
            if (b * b <= x) r = b;
        end
        if (x - r * r > r) r = r + 1;
        return r;
    endfunction

endpackage

// File: rtl/qg_sat_shift.sv
module qg_sat_shift #(
    parameter int IN_W  = 37,
    parameter int SHIFT = 16,
    parameter int OUT_W = 18
) (
    input  logic signed [IN_W-1:0]  din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int EXT_W = IN_W - OUT_W + 1;
    localparam logic signed [IN_W-1:0] MAXV = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] MINV = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [IN_W-1:0] shifted;

    always_comb begin
        shifted = din >>> SHIFT;
        if (shifted > MAXV)
            dout = MAXV[OUT_W-1:0];
        else if (shifted < MINV)
            dout = MINV[OUT_W-1:0];
        else
            dout = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/qg_hadamard.sv
module qg_hadamard #(
    parameter int FRAC_BITS = 16
) (
    input  logic [1:0][FRAC_BITS+1:0] a_in,
    input  logic [1:0][FRAC_BITS+1:0] b_in,
    output logic [1:0][FRAC_BITS+1:0] a_out,
    output logic [1:0][FRAC_BITS+1:0] b_out
);
    import qg_pkg::*;

    localparam int W  = FRAC_BITS + 2;
    localparam int PW = 2 * W + 1;
    localparam longint KVAL = inv_sqrt2_code(FRAC_BITS);
    localparam logic signed [PW-1:0] KX = PW'(KVAL);

    for (genvar lane = 0; lane < 2; lane++) begin : g_lane
        logic signed [W:0]    sum_w;
        logic signed [W:0]    dif_w;
        logic signed [PW-1:0] sum_x;
        logic signed [PW-1:0] dif_x;
        logic signed [PW-1:0] sum_p;
        logic signed [PW-1:0] dif_p;

        always_comb begin
            sum_w = $signed({a_in[lane][W-1], a_in[lane]}) + $signed({b_in[lane][W-1], b_in[lane]});
            dif_w = $signed({a_in[lane][W-1], a_in[lane]}) - $signed({b_in[lane][W-1], b_in[lane]});
            sum_x = {{(PW-W-1){sum_w[W]}}, sum_w};
            dif_x = {{(PW-W-1){dif_w[W]}}, dif_w};
            sum_p = sum_x * KX;
            dif_p = dif_x * KX;
        end

        qg_sat_shift #(.IN_W(PW), .SHIFT(FRAC_BITS), .OUT_W(W)) u_sat_sum (
            .din  (sum_p),
            .dout (a_out[lane])
        );
        qg_sat_shift #(.IN_W(PW), .SHIFT(FRAC_BITS), .OUT_W(W)) u_sat_dif (
            .din  (dif_p),
            .dout (b_out[lane])
        );
    end
endmodule

// File: rtl/qg_phase_mul.sv
module qg_phase_mul #(
    parameter int FRAC_BITS = 16
) (
    input  logic [FRAC_BITS+1:0] b_re,
    input  logic [FRAC_BITS+1:0] b_im,
    input  logic [FRAC_BITS+1:0] ph_c,
    input  logic [FRAC_BITS+1:0] ph_s,
    output logic [FRAC_BITS+1:0] r_re,
    output logic [FRAC_BITS+1:0] r_im
);
    localparam int W  = FRAC_BITS + 2;
    localparam int PW = 2 * W + 1;

    logic signed [PW-1:0] br_x, bi_x, c_x, s_x;
    logic signed [PW-1:0] p_rc, p_is, p_rs, p_ic;
    logic signed [PW-1:0] acc_re, acc_im;

    always_comb begin
        br_x   = {{(PW-W){b_re[W-1]}}, b_re};
        bi_x   = {{(PW-W){b_im[W-1]}}, b_im};
        c_x    = {{(PW-W){ph_c[W-1]}}, ph_c};
        s_x    = {{(PW-W){ph_s[W-1]}}, ph_s};
        p_rc   = br_x * c_x;
        p_is   = bi_x * s_x;
        p_rs   = br_x * s_x;
        p_ic   = bi_x * c_x;
        acc_re = p_rc - p_is;
        acc_im = p_rs + p_ic;
    end

    qg_sat_shift #(.IN_W(PW), .SHIFT(FRAC_BITS), .OUT_W(W)) u_sat_re (
        .din  (acc_re),
        .dout (r_re)
    );
    qg_sat_shift #(.IN_W(PW), .SHIFT(FRAC_BITS), .OUT_W(W)) u_sat_im (
        .din  (acc_im),
        .dout (r_im)
    );
endmodule

// File: rtl/qg_stage_ctrl.sv
module qg_stage_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    import qg_pkg::*;

    stage_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        state_d   = state_q;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && !in_valid) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
        load = in_valid && in_ready;
    end

    AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R2
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R1
    AST_STALL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R2
endmodule

// File: rtl/qubit_gate_stage.sv
module qubit_gate_stage #(
    parameter int FRAC_BITS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_op,
    input  logic [FRAC_BITS+1:0] in_a_re,
    input  logic [FRAC_BITS+1:0] in_a_im,
    input  logic [FRAC_BITS+1:0] in_b_re,
    input  logic [FRAC_BITS+1:0] in_b_im,
    input  logic [FRAC_BITS+1:0] in_cos,
    input  logic [FRAC_BITS+1:0] in_sin,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [FRAC_BITS+1:0] out_a_re,
    output logic [FRAC_BITS+1:0] out_a_im,
    output logic [FRAC_BITS+1:0] out_b_re,
    output logic [FRAC_BITS+1:0] out_b_im
);
    import qg_pkg::*;

    localparam int W = FRAC_BITS + 2;

    logic load;
    gate_op_e op;
    logic [1:0][W-1:0] a_vec, b_vec;
    logic [1:0][W-1:0] h_a, h_b;
    logic [1:0][W-1:0] z_b;
    logic [W-1:0] ph_re, ph_im;
    logic [W-1:0] nx_a_re, nx_a_im, nx_b_re, nx_b_im;

    assign op    = gate_op_e'(in_op);
    assign a_vec = {in_a_im, in_a_re};
    assign b_vec = {in_b_im, in_b_re};

    qg_stage_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load)
    );

    qg_hadamard #(.FRAC_BITS(FRAC_BITS)) u_had (
        .a_in  (a_vec),
        .b_in  (b_vec),
        .a_out (h_a),
        .b_out (h_b)
    );

    qg_phase_mul #(.FRAC_BITS(FRAC_BITS)) u_phase (
        .b_re (in_b_re),
        .b_im (in_b_im),
        .ph_c (in_cos),
        .ph_s (in_sin),
        .r_re (ph_re),
        .r_im (ph_im)
    );

    for (genvar lane = 0; lane < 2; lane++) begin : g_zneg
        logic signed [W:0] neg_w;
        assign neg_w = -$signed({b_vec[lane][W-1], b_vec[lane]});
        qg_sat_shift #(.IN_W(W+1), .SHIFT(0), .OUT_W(W)) u_sat_neg (
            .din  (neg_w),
            .dout (z_b[lane])
        );
    end

    always_comb begin
        unique case (op)
            OP_X: begin
                nx_a_re = in_b_re;  nx_a_im = in_b_im;
                nx_b_re = in_a_re;  nx_b_im = in_a_im;
            end
            OP_Z: begin
                nx_a_re = in_a_re;  nx_a_im = in_a_im;
                nx_b_re = z_b[0];   nx_b_im = z_b[1];
            end
            OP_H: begin
                nx_a_re = h_a[0];   nx_a_im = h_a[1];
                nx_b_re = h_b[0];   nx_b_im = h_b[1];
            end
            OP_PHASE: begin
                nx_a_re = in_a_re;  nx_a_im = in_a_im;
                nx_b_re = ph_re;    nx_b_im = ph_im;
            end
            default: begin
                nx_a_re = in_a_re;  nx_a_im = in_a_im;
                nx_b_re = in_b_re;  nx_b_im = in_b_im;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_a_re <= '0;
            out_a_im <= '0;
            out_b_re <= '0;
            out_b_im <= '0;
        end else if (load) begin
            out_a_re <= nx_a_re;
            out_a_im <= nx_a_im;
            out_b_re <= nx_b_re;
            out_b_im <= nx_b_im;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_a_re) && $stable(out_a_im)
                                       && $stable(out_b_re) && $stable(out_b_im))); // R2
    AST_X_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_op == 2'b00) |=> (out_a_re == $past(in_b_re) && out_a_im == $past(in_b_im)
                                      && out_b_re == $past(in_a_re) && out_b_im == $past(in_a_im))); // R3
    AST_ALPHA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_op[0]) |=> (out_a_re == $past(in_a_re) && out_a_im == $past(in_a_im))); // R4
    AST_H_ZERO_BETA: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_op == 2'b10 && in_b_re == '0 && in_b_im == '0)
            |=> (out_a_re == out_b_re && out_a_im == out_b_im)); // R5
endmodule

// File: tb/qubit_gate_stage_tb.sv
module qubit_gate_stage_tb;
    localparam int N = 16;
    localparam int W = N + 2;
    localparam longint MAXC = (longint'(1) << (N + 1)) - 1;
    localparam longint MINC = -(longint'(1) << (N + 1));
    localparam longint ONE  = longint'(1) << N;
    localparam longint KH   = 46341;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_op = 2'b00;
    logic [W-1:0] in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
    logic [W-1:0] in_cos = '0, in_sin = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [W-1:0] out_a_re, out_a_im, out_b_re, out_b_im;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    qubit_gate_stage #(.FRAC_BITS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re),
        .in_b_im(in_b_im), .in_cos(in_cos), .in_sin(in_sin), .out_valid(out_valid),
        .out_ready(out_ready), .out_a_re(out_a_re), .out_a_im(out_a_im),
        .out_b_re(out_b_re), .out_b_im(out_b_im)
    );

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(input string req, input string what, input longint act,
                              input longint exp, input longint tol);
        longint d;
        d = act - exp;
        if (d < 0) d = -d;
        n_tests++;
        if (d > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (+-%0d)", req, what, act, exp, tol);
        end
    endtask

    task automatic drive(input logic [1:0] op, input longint ar, input longint ai,
                         input longint br, input longint bi, input longint c, input longint s);
        in_op   = op;
        in_a_re = W'(ar); in_a_im = W'(ai);
        in_b_re = W'(br); in_b_im = W'(bi);
        in_cos  = W'(c);  in_sin  = W'(s);
    endtask

    // one transfer with out_ready high; results checked at the next falling edge
    task automatic xfer(input logic [1:0] op, input longint ar, input longint ai,
                        input longint br, input longint bi, input longint c, input longint s);
        @(negedge clk);
        drive(op, ar, ai, br, bi, c, s);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input longint ar, input longint ai,
                              input longint br, input longint bi);
        check(req, "out_valid", longint'(out_valid), 1);
        check(req, "a_re", sx(out_a_re), ar);
        check(req, "a_im", sx(out_a_im), ai);
        check(req, "b_re", sx(out_b_re), br);
        check(req, "b_im", sx(out_b_im), bi);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", longint'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_valid after reset", longint'(out_valid), 0);
        check("R1", "in_ready after reset", longint'(in_ready), 1);
    endtask

    task automatic t_x_gate();
        xfer(2'b00, 100, -200, 300, -400, 0, 0);
        expect_out("R3", 300, -400, 100, -200);
        xfer(2'b00, MAXC, MINC, 0, 7, 0, 0);
        expect_out("R3", 0, 7, MAXC, MINC);
    endtask

    task automatic t_z_gate();
        xfer(2'b01, 11, -22, 500, -1234, 0, 0);
        expect_out("R4", 11, -22, -500, 1234);
        xfer(2'b01, 1, 2, MINC, MAXC, 0, 0);
        expect_out("R4 R8", 1, 2, MAXC, -MAXC);
    endtask

    task automatic t_hadamard();
        xfer(2'b10, ONE, 0, 0, 0, 0, 0);
        expect_out("R5", KH, 0, KH, 0);
        xfer(2'b10, 0, 0, ONE, -ONE, 0, 0);
        expect_out("R5", KH, -KH, -KH, KH);
        // floor of tiny products: +1 -> 0, -1 -> -1
        xfer(2'b10, 1, -1, 0, 0, 0, 0);
        expect_out("R5", 0, -1, 0, -1);
        // sum of two near-maximum values overflows
        xfer(2'b10, MAXC, MINC, MAXC, MINC, 0, 0);
        expect_out("R8", MAXC, MINC, 0, 0);
    endtask

    task automatic t_phase();
        xfer(2'b11, 5, 6, 100, 200, 0, ONE);
        expect_out("R6", 5, 6, -200, 100);
        xfer(2'b11, -5, 9, 100, 200, -ONE, 0);
        expect_out("R6", -5, 9, -100, -200);
        // (1.5+1.5i)*(1.5+1.5i) = 0 + 4.5i -> imaginary part saturates
        xfer(2'b11, 0, 0, 3 * ONE / 2, 3 * ONE / 2, 3 * ONE / 2, 3 * ONE / 2);
        expect_out("R8", 0, 0, 0, MAXC);
    endtask

    task automatic t_accuracy();
        xfer(2'b10, KH, 0, KH, 0, 0, 0);
        check_near("R7", "H alpha ~ 1.0", sx(out_a_re), ONE, 2);
        check_near("R7", "H beta ~ 0", sx(out_b_re), 0, 2);
        xfer(2'b11, KH, 0, KH, 0, KH, KH);
        check_near("R7", "phase beta re ~ 0.5", sx(out_b_re), ONE / 2, 2);
        check_near("R7", "phase beta im ~ 0.5", sx(out_b_im), ONE / 2, 2);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        drive(2'b00, 1, 2, 3, 4, 0, 0);
        in_valid = 1'b1;
        @(negedge clk);
        drive(2'b01, 9, 9, 9, 9, 0, 0);
        for (int i = 0; i < 3; i++) begin
            check("R2", "in_ready in stall", longint'(in_ready), 0);
            expect_out("R2", 3, 4, 1, 2);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        expect_out("R2", 9, 9, -9, -9);
        @(negedge clk);
        check("R2", "out_valid drained", longint'(out_valid), 0);
    endtask

    task automatic t_stream();
        @(negedge clk);
        in_valid = 1'b1;
        for (int i = 0; i < 4; i++) begin
            drive(2'b00, i, 0, 10 + i, 0, 0, 0);
            @(negedge clk);
            check("R9", "in_ready", longint'(in_ready), 1);
            expect_out("R9", 10 + i, 0, i, 0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R9", "out_valid after stream", longint'(out_valid), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_x_gate();
        t_z_gate();
        t_hadamard();
        t_phase();
        t_accuracy();
        t_backpressure();
        t_stream();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule